// File: doc/BRIEF.md
# Bidirectional Cascaded Gate Scan Sequencer

This block is the digital core of a row-scan driver for an active-matrix display panel. An active-low start pulse, sampled on the vertical shift clock, launches a scan. The block then raises its row outputs one position per clock, moving up or down the bank according to a direction input. Each output is one logic bit: 1 means the row is selected and driven to the high rail, and 0 means the row is not selected.

Two instances can be chained so that together they cover twice the rows. No carry wire joins them. Both instances see the same start pulse and clock. Each one works out its own place in the chain from two pins and counts clocks internally. The instance in second place therefore starts exactly when the first one finishes.

A two-bit mode input picks the pulse shape: single-pulse scanning, overlapping double-pulse scanning, or interleaved double-pulse scanning. It can also force every row off.

Top module: `gate_scan_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `row_out` becomes all zeros after that edge and any scan in progress is dropped. With `spv_n` held high after reset, the outputs stay zero.
- R2: A scan starts at the first clock edge where `spv_n` is sampled low after it was sampled high (the sample taken in reset counts as high). Further low samples in the same low period do not start the scan again.
- R3: Scan slot s counts edges since the start edge, with the start edge as slot 0. The output shown after each edge reflects the slot of that edge. The whole scan lasts slots 0 to 2N+1, where N is `ROWS`.
- R4: The instance in first place uses local slot = s. The instance in second place uses local slot = s - N and is silent for s < N. A second-place instance therefore raises its first row N clocks after a first-place instance.
- R5: With `scan_dir`=1, scan position k drives `row_out[k]`, so row 1 leads. With `scan_dir`=0, scan position k drives `row_out[N-1-k]`.
- R6: The instance is in first place when `casc_en` equals `scan_dir`, and in second place otherwise.
- R7: When `mode_sel`=2'b11 (single pulse), position k is high only when local slot = k. At most one output is high at a time. After local slot N-1, all outputs stay low until the next start.
- R8: When `mode_sel`=2'b01 (overlapping double pulse), position k is high when local slot = k or k+1. Adjacent rows overlap by one period.
- R9: When `mode_sel`=2'b10 (interleaved double pulse), position k is high when local slot = k or k+2.
- R10: When `mode_sel`=2'b00, all outputs are 0 after the edge, whatever the scan state.
- R11: A start during a scan restarts it at slot 0 in the current direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Vertical shift clock |
| rst | input | 1 | Synchronous active-high reset |
| spv_n | input | 1 | Active-low scan start pulse |
| scan_dir | input | 1 | 1: scan from row_out[0] upward; 0: from row_out[ROWS-1] downward |
| casc_en | input | 1 | Chain place select, decoded together with scan_dir |
| mode_sel | input | 2 | Pulse shape: 11 single, 01 overlapping double, 10 interleaved double, 00 all off |
| row_out | output | ROWS | Registered row select outputs, 1 = selected |

## Verification
The assertions assume that `mode_sel`, `scan_dir` and `casc_en` are stable around each rising edge. They check the output against the mode sampled at the previous edge. The slot-counter properties assume that a start is recognised only through the sampled falling level of `spv_n`.

The bench changes every input on the falling clock edge, so each rising edge samples clean values. It walks through every chain place, both directions and all four modes. It also covers a start pulse held low for several clocks, a restart in mid-scan and a reset in mid-scan. A behavioural slot model predicts every output vector.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    SCAN_OFF    = 2'b00,
    SCAN_CONT   = 2'b01,
    SCAN_JUMP   = 2'b10,
    SCAN_SINGLE = 2'b11
  } scan_mode_e;

  // First place in the chain when the enable pin matches the direction pin.
  function automatic logic chain_first(input logic dir, input logic en);
    return dir == en;
  endfunction
endpackage

// File: rtl/gs_start_detect.sv
module gs_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic spv_n,
  output logic start_o
);
  logic spv_q;

  always_ff @(posedge clk) begin
    if (rst) spv_q <= 1'b1;
    else     spv_q <= spv_n;
  end

  // Low sample now, high sample at the previous edge.
  assign start_o = spv_q & ~spv_n;
endmodule

// File: rtl/gs_slot_counter.sv
module gs_slot_counter #(
  parameter int ROWS = 240,
  localparam int LAST = 2 * ROWS + 1,
  localparam int SW = $clog2(LAST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic [SW-1:0] slot_nxt_o,
  output logic          act_nxt_o
);
  localparam logic [SW-1:0] LAST_V = SW'(LAST);

  logic [SW-1:0] slot_q;
  logic          act_q;

  always_comb begin
    slot_nxt_o = slot_q;
    act_nxt_o  = act_q;
    if (start_i) begin
      slot_nxt_o = '0;
      act_nxt_o  = 1'b1;
    end else if (act_q) begin
      if (slot_q == LAST_V) act_nxt_o = 1'b0;
      else                  slot_nxt_o = slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      act_q  <= 1'b0;
    end else begin
      slot_q <= slot_nxt_o;
      act_q  <= act_nxt_o;
    end
  end

  // R11: a start always lands on slot 0 with the scan active
  a_r11_restart_zero: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (slot_q == '0) && act_q);

  // R3: one slot per clock while scanning
  a_r3_slot_advance: assert property (@(posedge clk) disable iff (rst)
    (act_q && !start_i && slot_q != LAST_V) |=> act_q && (slot_q == $past(slot_q) + SW'(1)));

  // R3: the scan ends after the last slot
  a_r3_scan_ends: assert property (@(posedge clk) disable iff (rst)
    (act_q && !start_i && slot_q == LAST_V) |=> !act_q);

  // R2: only a start wakes an idle counter
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !start_i) |=> !act_q);
endmodule

// File: rtl/gs_row_decoder.sv
module gs_row_decoder #(
  parameter int ROWS = 240,
  parameter int SW = 9
) (
  input  logic          [SW-1:0]   slot_i,
  input  logic                     act_i,
  input  logic                     dir_i,
  input  logic                     first_i,
  input  gs_pkg::scan_mode_e       mode_i,
  output logic          [ROWS-1:0] hit_o
);
  import gs_pkg::*;

  localparam logic [SW-1:0] OFFSET = SW'(ROWS);

  logic [SW-1:0] loc;
  logic          loc_ok;
  logic          cont_en;
  logic          jump_en;

  assign loc_ok  = act_i && (mode_i != SCAN_OFF) && (first_i || slot_i >= OFFSET);
  assign loc     = first_i ? slot_i : slot_i - OFFSET;
  assign cont_en = (mode_i == SCAN_CONT);
  assign jump_en = (mode_i == SCAN_JUMP);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam logic [SW-1:0] POS_UP = SW'(i);
    localparam logic [SW-1:0] POS_DN = SW'(ROWS - 1 - i);
    logic [SW-1:0] pos;
    assign pos = dir_i ? POS_UP : POS_DN;
    assign hit_o[i] = loc_ok && ((loc == pos)
                              || (cont_en && loc == pos + SW'(1))
                              || (jump_en && loc == pos + SW'(2)));
  end
endmodule

// File: rtl/gate_scan_seq.sv
module gate_scan_seq #(
  parameter int ROWS = 240,
  localparam int SW = $clog2(2 * ROWS + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spv_n,
  input  logic            scan_dir,
  input  logic            casc_en,
  input  logic [1:0]      mode_sel,
  output logic [ROWS-1:0] row_out
);
  import gs_pkg::*;

  logic            start;
  logic [SW-1:0]   slot_nxt;
  logic            act_nxt;
  logic [ROWS-1:0] hit;
  scan_mode_e      mode;

  assign mode = scan_mode_e'(mode_sel);

  gs_start_detect u_start (
    .clk     (clk),
    .rst     (rst),
    .spv_n   (spv_n),
    .start_o (start)
  );

  gs_slot_counter #(.ROWS(ROWS)) u_count (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .slot_nxt_o (slot_nxt),
    .act_nxt_o  (act_nxt)
  );

  gs_row_decoder #(.ROWS(ROWS), .SW(SW)) u_dec (
    .slot_i  (slot_nxt),
    .act_i   (act_nxt),
    .dir_i   (scan_dir),
    .first_i (chain_first(scan_dir, casc_en)),
    .mode_i  (mode),
    .hit_o   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) row_out <= '0;
    else     row_out <= hit;
  end

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> row_out == '0);

  // R10: forced-off mode keeps every row low
  a_r10_all_off: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> row_out == '0);

  // R7: single-pulse mode selects at most one row
  a_r7_single_onehot: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> $onehot0(row_out));

  // R8: overlapping mode selects at most two rows
  a_r8_cont_pair: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> $countones(row_out) <= 2);

  // R9: interleaved mode selects at most two rows
  a_r9_jump_pair: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10) |=> $countones(row_out) <= 2);
endmodule

// File: tb/tb_gate_scan_seq.sv
module tb_gate_scan_seq;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         spv_n = 1'b1;
  logic         scan_dir = 1'b1;
  logic         casc_en = 1'b1;
  logic [1:0]   mode_sel = 2'b11;
  logic [N-1:0] row_out;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  int m_slot = 0;
  bit m_act = 0;
  bit m_prev = 1;

  always #4 clk = ~clk;

  gate_scan_seq #(.ROWS(N)) dut (
    .clk(clk), .rst(rst), .spv_n(spv_n), .scan_dir(scan_dir),
    .casc_en(casc_en), .mode_sel(mode_sel), .row_out(row_out)
  );

  function automatic logic [N-1:0] expect_rows(bit d, bit e, logic [1:0] m);
    logic [N-1:0] v = '0;
    int off = (d == e) ? 0 : N;
    int loc = m_slot - off;
    for (int i = 0; i < N; i++) begin
      int k = d ? i : N - 1 - i;
      if (m_act && m != 2'b00 && loc >= 0)
        v[i] = (loc == k) || (m == 2'b01 && loc == k + 1) || (m == 2'b10 && loc == k + 2);
    end
    return v;
  endfunction

  task automatic step(input bit r, input bit sp, input bit d, input bit e,
                      input logic [1:0] m, input string tag);
    logic [N-1:0] exp_v;
    @(negedge clk);
    rst = r; spv_n = sp; scan_dir = d; casc_en = e; mode_sel = m;
    @(posedge clk);
    if (r) begin
      m_slot = 0; m_act = 0; m_prev = 1;
    end else begin
      if (!sp && m_prev) begin
        m_slot = 0; m_act = 1;
      end else if (m_act) begin
        if (m_slot == 2 * N + 1) m_act = 0;
        else m_slot++;
      end
      m_prev = sp;
    end
    exp_v = r ? '0 : expect_rows(d, e, m);
    #1;
    compared++;
    if (row_out !== exp_v) begin
      mismatched++;
      $display("FAIL %s: row_out=%b expected=%b", tag, row_out, exp_v);
    end
  endtask

  task automatic scan(input bit d, input bit e, input logic [1:0] m,
                      input int low_len, input int tail, input string tag);
    for (int i = 0; i < low_len; i++) step(0, 0, d, e, m, tag);
    for (int i = 0; i < tail; i++) step(0, 1, d, e, m, tag);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 2'b11, "R1");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 2'b11, "R1");
    // R3 R5 R6 R7: first place, upward, single pulse
    scan(1, 1, 2'b11, 1, 2 * N + 4, "R7");
    // R4 R6: second place, upward
    scan(1, 0, 2'b11, 1, 2 * N + 4, "R4");
    // R5 R6: first place, downward
    scan(0, 0, 2'b11, 1, 2 * N + 4, "R5");
    // R4 R5: second place, downward
    scan(0, 1, 2'b11, 1, 2 * N + 4, "R6");
    // R8: overlapping double pulse, both places
    scan(1, 1, 2'b01, 1, 2 * N + 4, "R8");
    scan(0, 1, 2'b01, 1, 2 * N + 4, "R8");
    // R9: interleaved double pulse, both places
    scan(1, 1, 2'b10, 1, 2 * N + 4, "R9");
    scan(0, 0, 2'b10, 1, 2 * N + 4, "R9");
    scan(1, 0, 2'b10, 1, 2 * N + 4, "R9");
    // R10: forced off during a scan
    scan(1, 1, 2'b00, 1, 2 * N + 4, "R10");
    // R2: start pulse held low for several clocks
    scan(1, 1, 2'b11, 5, 2 * N + 4, "R2");
    // R11: restart in mid-scan, both directions
    scan(1, 1, 2'b11, 1, 5, "R11");
    scan(1, 1, 2'b11, 1, 2 * N + 4, "R11");
    scan(0, 0, 2'b01, 1, 3, "R11");
    scan(0, 0, 2'b01, 1, 2 * N + 4, "R11");
    // R1: reset in mid-scan drops the scan
    scan(1, 1, 2'b11, 1, 3, "R1");
    step(1, 1, 1, 1, 2'b11, "R1");
    for (int i = 0; i < 2 * N + 4; i++) step(0, 1, 1, 1, 2'b11, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule